// File: doc/BRIEF.md
# CPU Clock Source Select and Divider

This block produces the clock of a CPU domain from one of two input clocks, a primary and an alternate. It divides the chosen clock by an integer ratio. One 16-bit control word holds a source-select bit and a divider field. Software changes the word through a 32-bit write strobe. The upper half of each write is a per-bit enable for the lower half. Because of this, the select bit and the divider can both change in one write, and no read-modify-write is needed. The current control word can always be read back, so the output rate can be worked out as the source rate divided by the field plus one.

The switch between sources is glitch-free. The active source is gated off during its own low phase. The new source is gated on only after the old one is known to be off, and that knowledge passes through a two-flop synchroniser in the new source's domain. The divider runs on the selected clock. It takes a new ratio only at the end of a divided period, so no output phase is ever shorter than one phase of the source that produces it. When the ratio is zero, the selected clock passes straight through.

Top module: `clk_cpu_ctrl`

## Requirements
- R1: After reset the control word is zero and `rd_data` reads 0. `clk_out` then runs at the primary clock's period, with the primary's high time.
- R2: A write to the control address sets bit i (0..15) of the control word to `wr_data[i]` only when `wr_data[i+16]` is 1. Every bit whose enable is 0 keeps its old value.
- R3: The control word does not change when `wr_en` is low or when `wr_addr` differs from `REG_ADDR` (default 0x40).
- R4: Bit 7 of the control word selects the source: 0 selects `clk_pri` and 1 selects `clk_alt`. Once the switch has settled, `clk_out` is derived from the selected source only.
- R5: Bits [4:0] of the control word hold the divider field F. With N = F+1 and source period T, `clk_out` has period N*T. Its high time is T/2 when N = 1 and ceil(N/2)*T otherwise.
- R6: One write that enables both the select bit and divider bits updates both in the same clock cycle. The readback taken after that write shows both new values together.
- R7: The two source enables are never active at the same time. `clk_out` never shows a phase shorter than half of the faster source period.
- R8: The divider takes a new ratio only at the end of a divided period. Its internal count never exceeds the ratio in use.
- R9: `rd_data` returns the control word in bits [15:0] and zeros in bits [31:16]. It shows a write from the first `clk` edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; matched against REG_ADDR |
| wr_data | input | 32 | [31:16] per-bit enables, [15:0] new values |
| rd_data | output | 32 | Control word readback, zero-extended |
| clk_pri | input | 1 | Primary source clock |
| clk_alt | input | 1 | Alternate source clock |
| clk_out | output | 1 | Selected and divided CPU clock |

## Verification
A write is accepted on the first rising `clk` edge that sees the strobe. The readback is therefore due from that edge onward, and the bench samples it at the following falling edge. The output timing settles more slowly. It waits for the old source to be gated off on its falling edge, for two flops in the new source's domain, for three flops of ratio synchronisation in the output domain, and for the end of the current divided period. For that reason the bench waits a fixed 1 us after each configuration write, which is well above the worst case of those delays. It then discards one output period and times the next period and high phase against values it computes from the source periods. A pulse-width monitor watches every `clk_out` edge across all the switches, including the transitions.

// File: rtl/clk_cpu_ctrl_pkg.sv
package clk_cpu_ctrl_pkg;
  localparam int CW = 16;
  typedef logic [CW-1:0] ctrl_word_t;

  // Per-bit masked update: upper half enables, lower half values.
  function automatic ctrl_word_t masked_merge(ctrl_word_t cur, logic [2*CW-1:0] wr);
    ctrl_word_t en;
    en = wr[2*CW-1:CW];
    return (cur & ~en) | (wr[CW-1:0] & en);
  endfunction

  // Number of source cycles the divided clock stays high for a ratio field.
  function automatic int unsigned high_cycles(int unsigned ratio);
    return (ratio + 2) / 2;
  endfunction
endpackage

// File: rtl/clk_cpu_ctrl_regs.sv
module clk_cpu_ctrl_regs
  import clk_cpu_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_ADDR  = 'h40,
  parameter int SEL_BIT   = 7,
  parameter int DIV_SHIFT = 0,
  parameter int DIV_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2*CW-1:0]   wr_data,
  output ctrl_word_t        word_o,
  output logic              sel_o,
  output logic [DIV_W-1:0]  div_o
);
  ctrl_word_t word_q;
  logic       wr_hit;

  assign wr_hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (wr_hit) word_q <= masked_merge(word_q, wr_data);
  end

  assign word_o = word_q;
  assign sel_o  = word_q[SEL_BIT];
  assign div_o  = word_q[DIV_SHIFT +: DIV_W];

  AST_UNMASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((word_q ^ $past(word_q)) & ~$past(wr_data[2*CW-1:CW])) == 16'h0)); // R2
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(word_q)); // R3
endmodule

// File: rtl/clk_cpu_ctrl_gfmux.sv
module clk_cpu_ctrl_gfmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic sel,
  input  logic clk_pri,
  input  logic clk_alt,
  output logic clk_mux,
  output logic en_pri,
  output logic en_alt
);
  logic [SYNC_STAGES-1:0] pri_s, alt_s;
  logic req_pri, req_alt;
  logic pri_busy, alt_busy;

  // A side counts as busy while any stage of its chain or its enable is set.
  assign pri_busy = (|pri_s) | en_pri;
  assign alt_busy = (|alt_s) | en_alt;
  assign req_pri  = !sel && !alt_busy;
  assign req_alt  =  sel && !pri_busy;

  always_ff @(posedge clk_pri or negedge rst_n) begin
    if (!rst_n) pri_s <= '1;
    else        pri_s <= {pri_s[SYNC_STAGES-2:0], req_pri};
  end
  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) en_pri <= 1'b1;
    else        en_pri <= pri_s[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_alt or negedge rst_n) begin
    if (!rst_n) alt_s <= '0;
    else        alt_s <= {alt_s[SYNC_STAGES-2:0], req_alt};
  end
  always_ff @(negedge clk_alt or negedge rst_n) begin
    if (!rst_n) en_alt <= 1'b0;
    else        en_alt <= alt_s[SYNC_STAGES-1];
  end

  assign clk_mux = (clk_pri & en_pri) | (clk_alt & en_alt);

  always_comb begin
    if (rst_n) AST_ONE_SOURCE: assert (!(en_pri && en_alt)); // R7
  end
  AST_ALT_AFTER_PRI: assert property (@(negedge clk_alt) disable iff (!rst_n)
    $rose(en_alt) |-> !en_pri); // R7
  AST_PRI_AFTER_ALT: assert property (@(negedge clk_pri) disable iff (!rst_n)
    $rose(en_pri) |-> !en_alt); // R7
endmodule

// File: rtl/clk_cpu_ctrl_div.sv
module clk_cpu_ctrl_div
  import clk_cpu_ctrl_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             clk_o,
  output logic             at_end,
  output logic [DIV_W-1:0] ratio_q
);
  logic [DIV_W-1:0] s1, s2, s3;
  logic [DIV_W-1:0] cnt_q;
  logic             out_q;
  logic             cfg_steady;

  // Ratio crosses in as a quasi-static bus; two equal samples mean no skew.
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= div_cfg; s2 <= s1; s3 <= s2;
    end
  end
  assign cfg_steady = (s2 == s3);
  assign at_end     = (cnt_q == ratio_q);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      out_q   <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      out_q <= 1'b1;
      if (cfg_steady) ratio_q <= s2;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      out_q <= (32'(cnt_q) + 32'd1) < high_cycles(32'(ratio_q));
    end
  end

  // Ratio zero passes the selected clock straight through.
  assign clk_o = (ratio_q == '0) ? clk_in : out_q;

  AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q <= ratio_q); // R8
  AST_LOAD_AT_END: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> $past(at_end)); // R8
endmodule

// File: rtl/clk_cpu_ctrl.sv
module clk_cpu_ctrl
  import clk_cpu_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_ADDR  = 'h40,
  parameter int SEL_BIT   = 7,
  parameter int DIV_SHIFT = 0,
  parameter int DIV_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              clk_pri,
  input  logic              clk_alt,
  output logic              clk_out
);
  ctrl_word_t       word;
  logic             sel;
  logic [DIV_W-1:0] div;
  logic             clk_mux, en_pri, en_alt;
  logic             div_end;
  logic [DIV_W-1:0] div_ratio;

  clk_cpu_ctrl_regs #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SEL_BIT(SEL_BIT),
    .DIV_SHIFT(DIV_SHIFT), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .word_o(word), .sel_o(sel), .div_o(div)
  );

  clk_cpu_ctrl_gfmux #(.SYNC_STAGES(2)) u_mux (
    .rst_n(rst_n), .sel(sel), .clk_pri(clk_pri), .clk_alt(clk_alt),
    .clk_mux(clk_mux), .en_pri(en_pri), .en_alt(en_alt)
  );

  clk_cpu_ctrl_div #(.DIV_W(DIV_W)) u_div (
    .clk_in(clk_mux), .rst_n(rst_n), .div_cfg(div),
    .clk_o(clk_out), .at_end(div_end), .ratio_q(div_ratio)
  );

  assign rd_data = {16'h0, word};

  AST_READBACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0); // R9
  AST_RATIO_NEVER_PAST_END: assert property (@(posedge clk_mux) disable iff (!rst_n)
    !div_end |=> $stable(div_ratio)); // R8
endmodule

// File: tb/sim_clk_cpu_ctrl.sv
`timescale 1ns/1ps
module sim_clk_cpu_ctrl;
  localparam real TPRI = 6.0;
  localparam real TALT = 10.0;
  localparam logic [7:0] ADDR = 8'h40;

  logic        clk = 0, clk_pri = 0, clk_alt = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        clk_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always #(TPRI/2) clk_pri = ~clk_pri;
  always #(TALT/2) clk_alt = ~clk_alt;

  clk_cpu_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .clk_pri(clk_pri),
    .clk_alt(clk_alt), .clk_out(clk_out)
  );

  // Pulse-width monitor over every clk_out phase.
  bit      mon_on = 0;
  realtime last_edge = 0;
  real     min_pulse = 1.0e9;
  always @(clk_out) begin
    if (mon_on) begin
      if (last_edge > 0 && ($realtime - last_edge) < min_pulse) min_pulse = $realtime - last_edge;
      last_edge = $realtime;
    end
  end

  task automatic chk_val(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_time(string req, real act, real exp);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    @(posedge clk_out);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0; hi = t1 - t0;
  endtask

  function automatic real exp_high(int n, real t);
    if (n == 1) return t / 2.0;
    return (n - n / 2) * t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] model;
    logic [31:0] x;
    real per, hi;

    #50 rst_n = 1;
    @(negedge clk);
    // R1: reset state and primary pass-through
    chk_val("R1 readback", rd_data, 32'h0);
    #500;
    measure(per, hi);
    chk_time("R1 period", per, TPRI);
    chk_time("R1 high", hi, TPRI / 2.0);

    // R2 R9: masked writes with a bench-side model
    model = 16'h0;
    x = 32'h1234_5678;
    for (int i = 0; i < 48; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      wr(ADDR, x);
      model = (model & ~x[31:16]) | (x[15:0] & x[31:16]);
      chk_val("R2 R9 masked write", rd_data, {16'h0, model});
    end
    wr(ADDR, 32'hFFFF_0000);
    chk_val("R2 full clear", rd_data, 32'h0);
    wr(ADDR, 32'h0000_FFFF);
    chk_val("R2 no enables", rd_data, 32'h0);

    // R3: wrong address and strobe low
    wr(8'h41, 32'hFFFF_FFFF);
    chk_val("R3 wrong address", rd_data, 32'h0);
    @(negedge clk);
    wr_addr = ADDR; wr_data = 32'hFFFF_FFFF; wr_en = 0;
    @(negedge clk);
    chk_val("R3 strobe low", rd_data, 32'h0);

    // R6: select and divider change in one write
    wr(ADDR, 32'h009F_0085);
    chk_val("R6 both fields", rd_data, 32'h85);
    #1000;
    measure(per, hi);
    chk_time("R6 alt div6 period", per, 6 * TALT);
    chk_time("R6 alt div6 high", hi, exp_high(6, TALT));
    wr(ADDR, 32'h009F_0003);
    chk_val("R6 both fields back", rd_data, 32'h03);
    #1000;

    // R4 R5: sweep both sources and all divider values
    mon_on = 1; last_edge = 0;
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 32; d++) begin
        real t;
        t = (s == 1) ? TALT : TPRI;
        wr(ADDR, 32'h009F_0000 | 32'(s << 7) | 32'(d));
        chk_val("R4 R5 readback", rd_data, 32'(s << 7) | 32'(d));
        #1000;
        measure(per, hi);
        chk_time("R4 R5 period", per, (d + 1) * t);
        chk_time("R5 high", hi, exp_high(d + 1, t));
      end
    end
    wr(ADDR, 32'h009F_0000);
    #1000;
    mon_on = 0;
    // R7 R8: no phase shorter than half the faster source period
    checks++;
    if (min_pulse < TPRI / 2.0 - 0.01) begin
      errors++;
      $display("FAIL R7 R8 min pulse: actual %0.3f expected >= %0.3f", min_pulse, TPRI / 2.0);
    end
    finish_run();
  end
endmodule